// File: doc/BRIEF.md
# Multi-Channel DMA Register File

This block is the control and status register store that sits beside a multi-channel memory-access engine. It serves a configurable number of transmit and receive channels, at most 32 of each. Software reaches it through one register port: a write strobe, a 10-bit address and a 32-bit write word. The read word is a combinational function of the address and of the stored state. The engine itself is outside this block. The engine reports events through five 32-bit status-set strobe vectors. It reads back the global configuration and the four channel-activation masks through dedicated outputs.

The block holds:
- a global configuration word;
- an error status word;
- a five-bit interrupt enable;
- channel-activation set and reset masks for each direction;
- end-of-buffer and descriptor-error status for each direction;
- a descriptor table pointer for every channel;
- a buffer size for every receive channel.

Writing the configuration word with bit 31 set first clears every resettable register, then stores the new masked value. Five interrupt lines each report one status group, gated by its enable bit.

Top module: `mchan_dma_regs`

## Requirements
- R1: After reset, configuration (0x180) reads 0x0007C000. The error status, interrupt enable, the four activation masks and the four channel status words all read 0.
- R2: A write to configuration (0x180) stores the written word ANDed with 0x00FFC087. The stored value appears on `cfg_o` and on reads from the cycle after the write edge.
- R3: A configuration write with bit 31 set first clears the following registers, then stores the masked value: error status, interrupt enable, all activation masks and all channel status words. Table pointers and buffer sizes keep their contents.
- R4: Five status words are write-one-to-clear: error status 0x181, transmit end-of-buffer 0x186, transmit descriptor error 0x187, receive end-of-buffer 0x192 and receive descriptor error 0x193. Writing a 1 clears that bit, and writing a 0 leaves it unchanged.
- R5: Set strobes OR into the matching status word on each clock edge. The strobes are `err_set`, `tx_eob_set`, `tx_derr_set`, `rx_eob_set` and `rx_derr_set`. A set and a clear of the same bit in the same cycle leave the bit set.
- R6: Interrupt enable (0x182) keeps bits 4:0. Transmit activation set and reset (0x184, 0x185) keep bits 31:28. Receive activation set and reset (0x190, 0x191) keep bits 31:30. All other bits of these registers read 0.
- R7: Transmit table pointers (0x1A0+n) and receive table pointers (0x1C0+n) store all 32 bits. Receive buffer sizes (0x1E0+n) store bits 7:0 only.
- R8: A window address whose index n is at or beyond the channel count reads 0, and a write to it changes nothing. The channel count is `TX_CH` for the transmit pointers and `RX_CH` for the receive windows. An unmapped address such as 0x183 also reads 0.
- R9: `irq_o[k]` is high exactly when enable bit k is set and status word k is nonzero. The groups are k=0 error, k=1 transmit end-of-buffer, k=2 transmit descriptor error, k=3 receive end-of-buffer, k=4 receive descriptor error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register address |
| reg_wdata | input | 32 | Write word |
| reg_rdata | output | 32 | Read word for `reg_addr` (combinational) |
| err_set | input | 32 | Error status set strobes |
| tx_eob_set | input | 32 | Transmit end-of-buffer set strobes |
| tx_derr_set | input | 32 | Transmit descriptor-error set strobes |
| rx_eob_set | input | 32 | Receive end-of-buffer set strobes |
| rx_derr_set | input | 32 | Receive descriptor-error set strobes |
| cfg_o | output | 32 | Stored configuration word |
| tx_act_set_o | output | 32 | Transmit activation set mask |
| tx_act_rst_o | output | 32 | Transmit activation reset mask |
| rx_act_set_o | output | 32 | Receive activation set mask |
| rx_act_rst_o | output | 32 | Receive activation reset mask |
| irq_o | output | 5 | Gated interrupt per status group |

## Verification
Configuration writes are tried with bit 31 clear and with bit 31 set. The two patterns separate plain masking from the soft reset, which must clear the other registers yet spare the table pointers.

Status words are driven in three ways:
- by strobes alone;
- by one-clears alone, on a mix of set and unset bits;
- by a strobe and a one-clear on the same bit in the same cycle.

Together these show accumulation, selective clearing and the set-over-clear priority.

Window accesses use the last valid index and the first invalid index, which exposes off-by-one errors in the range decode. Interrupts are checked with the enable on and then off for an active group, and with a group whose status is zero.

// File: rtl/mdr_pkg.sv
package mdr_pkg;
  localparam int unsigned AW   = 10;
  localparam int unsigned DW   = 32;
  localparam int unsigned NGRP = 5;

  localparam logic [AW-1:0] A_CFG    = 10'h180;
  localparam logic [AW-1:0] A_ERR    = 10'h181;
  localparam logic [AW-1:0] A_IER    = 10'h182;
  localparam logic [AW-1:0] A_TXASET = 10'h184;
  localparam logic [AW-1:0] A_TXARST = 10'h185;
  localparam logic [AW-1:0] A_TXEOB  = 10'h186;
  localparam logic [AW-1:0] A_TXDERR = 10'h187;
  localparam logic [AW-1:0] A_RXASET = 10'h190;
  localparam logic [AW-1:0] A_RXARST = 10'h191;
  localparam logic [AW-1:0] A_RXEOB  = 10'h192;
  localparam logic [AW-1:0] A_RXDERR = 10'h193;
  localparam logic [AW-1:0] A_TXPTR  = 10'h1A0;
  localparam logic [AW-1:0] A_RXPTR  = 10'h1C0;
  localparam logic [AW-1:0] A_RXBSZ  = 10'h1E0;

  localparam logic [DW-1:0] CFG_RST   = 32'h0007_C000;
  localparam logic [DW-1:0] CFG_KEEP  = 32'h00FF_C087;
  localparam logic [DW-1:0] IER_KEEP  = 32'h0000_001F;
  localparam logic [DW-1:0] TXA_KEEP  = 32'hF000_0000;
  localparam logic [DW-1:0] RXA_KEEP  = 32'hC000_0000;
  localparam logic [DW-1:0] BSZ_KEEP  = 32'h0000_00FF;
  localparam logic [DW-1:0] FULL_KEEP = 32'hFFFF_FFFF;

  // status group k sits at this address; group k is also gated by enable bit k
  function automatic logic [AW-1:0] grp_addr(input int unsigned k);
    case (k)
      0:       return A_ERR;
      1:       return A_TXEOB;
      2:       return A_TXDERR;
      3:       return A_RXEOB;
      default: return A_RXDERR;
    endcase
  endfunction

  function automatic logic in_window(input logic [AW-1:0] a,
                                     input logic [AW-1:0] base,
                                     input int unsigned   cnt);
    return (a >= base) && ({22'd0, a} < ({22'd0, base} + cnt));
  endfunction

  // one-clear then set: set takes priority
  function automatic logic [DW-1:0] w1c_next(input logic [DW-1:0] cur,
                                             input logic [DW-1:0] clr,
                                             input logic [DW-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/mdr_status_reg.sv
module mdr_status_reg
  import mdr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_clr,
  input  logic          clr_en,
  input  logic [DW-1:0] clr_val,
  input  logic [DW-1:0] set_val,
  output logic [DW-1:0] q
);
  logic [DW-1:0] clr_eff;
  logic [DW-1:0] base;

  assign clr_eff = clr_en ? clr_val : '0;
  assign base    = soft_clr ? '0 : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= w1c_next(base, clr_eff, set_val);
  end

  // R5: every strobed bit is set on the next cycle
  p_set_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_val != '0) |=> ((q & $past(set_val)) == $past(set_val)));

  // R4: a one-clear without a competing strobe empties the bit
  p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((q & $past(clr_val & ~set_val)) == '0));

  // R4: bits neither strobed nor cleared nor soft-reset hold
  p_w1c_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && !soft_clr && set_val == '0) |=> $stable(q));
endmodule

// File: rtl/mdr_chan_table.sv
module mdr_chan_table
  import mdr_pkg::*;
#(
  parameter int unsigned     DEPTH = 4,
  parameter logic [AW-1:0]   BASE  = 10'h1A0,
  parameter logic [DW-1:0]   KEEP  = 32'hFFFF_FFFF
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          hit,
  output logic [DW-1:0] rd_val
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] off;
  logic [IW-1:0] idx;

  assign off = addr - BASE;
  assign idx = off[IW-1:0];
  assign hit = in_window(addr, BASE, DEPTH);

  // contents intentionally survive reset and soft reset
  always_ff @(posedge clk) begin
    if (we && hit) mem[idx] <= wdata & KEEP;
  end

  assign rd_val = hit ? mem[idx] : '0;
endmodule

// File: rtl/mchan_dma_regs.sv
module mchan_dma_regs
  import mdr_pkg::*;
#(
  parameter int unsigned TX_CH = 4,
  parameter int unsigned RX_CH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [9:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [31:0]   err_set,
  input  logic [31:0]   tx_eob_set,
  input  logic [31:0]   tx_derr_set,
  input  logic [31:0]   rx_eob_set,
  input  logic [31:0]   rx_derr_set,
  output logic [31:0]   cfg_o,
  output logic [31:0]   tx_act_set_o,
  output logic [31:0]   tx_act_rst_o,
  output logic [31:0]   rx_act_set_o,
  output logic [31:0]   rx_act_rst_o,
  output logic [4:0]    irq_o
);
  logic [DW-1:0] cfg_q, ier_q, txas_q, txar_q, rxas_q, rxar_q;
  logic [DW-1:0] stat_q  [NGRP];
  logic [DW-1:0] stat_set[NGRP];
  logic          soft_evt;
  logic          wr_cfg, wr_ier;
  logic          txp_hit, rxp_hit, rxb_hit;
  logic [DW-1:0] txp_val, rxp_val, rxb_val;

  assign wr_cfg   = reg_we && (reg_addr == A_CFG);
  assign wr_ier   = reg_we && (reg_addr == A_IER);
  assign soft_evt = wr_cfg && reg_wdata[31];

  assign stat_set[0] = err_set;
  assign stat_set[1] = tx_eob_set;
  assign stat_set[2] = tx_derr_set;
  assign stat_set[3] = rx_eob_set;
  assign stat_set[4] = rx_derr_set;

  // plain control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      ier_q  <= '0;
      txas_q <= '0;
      txar_q <= '0;
      rxas_q <= '0;
      rxar_q <= '0;
    end else if (soft_evt) begin
      cfg_q  <= reg_wdata & CFG_KEEP;
      ier_q  <= '0;
      txas_q <= '0;
      txar_q <= '0;
      rxas_q <= '0;
      rxar_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CFG:    cfg_q  <= reg_wdata & CFG_KEEP;
        A_IER:    ier_q  <= reg_wdata & IER_KEEP;
        A_TXASET: txas_q <= reg_wdata & TXA_KEEP;
        A_TXARST: txar_q <= reg_wdata & TXA_KEEP;
        A_RXASET: rxas_q <= reg_wdata & RXA_KEEP;
        A_RXARST: rxar_q <= reg_wdata & RXA_KEEP;
        default: ;
      endcase
    end
  end

  // status groups
  for (genvar g = 0; g < NGRP; g++) begin : g_stat
    logic clr_here;
    assign clr_here = reg_we && (reg_addr == grp_addr(g));
    mdr_status_reg u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_evt),
      .clr_en   (clr_here),
      .clr_val  (reg_wdata),
      .set_val  (stat_set[g]),
      .q        (stat_q[g])
    );
    assign irq_o[g] = ier_q[g] && (stat_q[g] != '0);
  end

  // per-channel windows
  mdr_chan_table #(.DEPTH(TX_CH), .BASE(A_TXPTR), .KEEP(FULL_KEEP)) u_txptr (
    .clk(clk), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .hit(txp_hit), .rd_val(txp_val));
  mdr_chan_table #(.DEPTH(RX_CH), .BASE(A_RXPTR), .KEEP(FULL_KEEP)) u_rxptr (
    .clk(clk), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .hit(rxp_hit), .rd_val(rxp_val));
  mdr_chan_table #(.DEPTH(RX_CH), .BASE(A_RXBSZ), .KEEP(BSZ_KEEP)) u_rxbsz (
    .clk(clk), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .hit(rxb_hit), .rd_val(rxb_val));

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CFG:    reg_rdata = cfg_q;
      A_ERR:    reg_rdata = stat_q[0];
      A_IER:    reg_rdata = ier_q;
      A_TXASET: reg_rdata = txas_q;
      A_TXARST: reg_rdata = txar_q;
      A_TXEOB:  reg_rdata = stat_q[1];
      A_TXDERR: reg_rdata = stat_q[2];
      A_RXASET: reg_rdata = rxas_q;
      A_RXARST: reg_rdata = rxar_q;
      A_RXEOB:  reg_rdata = stat_q[3];
      A_RXDERR: reg_rdata = stat_q[4];
      default:  reg_rdata = txp_val | rxp_val | rxb_val;
    endcase
  end

  assign cfg_o        = cfg_q;
  assign tx_act_set_o = txas_q;
  assign tx_act_rst_o = txar_q;
  assign rx_act_set_o = rxas_q;
  assign rx_act_rst_o = rxar_q;

  // R3: soft reset empties the control registers it owns
  p_soft_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_evt |=> (ier_q == '0 && txas_q == '0 && txar_q == '0 &&
                  rxas_q == '0 && rxar_q == '0));

  // R6: enable changes only through its own write or a soft reset
  p_ier_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ier && !soft_evt) |=> $stable(ier_q));

  // R9: no interrupt line without its enable
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~ier_q[4:0]) == 5'd0));

  // R8: the three windows never decode the same address
  p_window_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({txp_hit, rxp_hit, rxb_hit}));
endmodule

// File: tb/mchan_dma_regs_bench.sv
module mchan_dma_regs_bench;
  localparam int TXN = 4;
  localparam int RXN = 2;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] err_set = '0, tx_eob_set = '0, tx_derr_set = '0;
  logic [31:0] rx_eob_set = '0, rx_derr_set = '0;
  logic [31:0] cfg_o, tx_act_set_o, tx_act_rst_o, rx_act_set_o, rx_act_rst_o;
  logic [4:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mchan_dma_regs #(.TX_CH(TXN), .RX_CH(RXN)) u_mchan_dma_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .err_set(err_set), .tx_eob_set(tx_eob_set), .tx_derr_set(tx_derr_set),
    .rx_eob_set(rx_eob_set), .rx_derr_set(rx_derr_set),
    .cfg_o(cfg_o), .tx_act_set_o(tx_act_set_o), .tx_act_rst_o(tx_act_rst_o),
    .rx_act_set_o(rx_act_set_o), .rx_act_rst_o(rx_act_rst_o), .irq_o(irq_o));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(10'h180, v); chk("R1 cfg", v, 32'h0007C000);
    chk("R1 cfg_o", cfg_o, 32'h0007C000);
    foreach (u_addr_list[i]) begin
      rd(u_addr_list[i], v); chk("R1 zero", v, 0);
    end
  endtask

  logic [9:0] u_addr_list [10] = '{10'h181, 10'h182, 10'h184, 10'h185, 10'h186,
                                   10'h187, 10'h190, 10'h191, 10'h192, 10'h193};

  task automatic t_cfg_mask;
    logic [31:0] v;
    wr(10'h180, 32'h7FFF_FFFF);
    rd(10'h180, v); chk("R2 cfg mask", v, 32'h00FFC087);
    chk("R2 cfg_o", cfg_o, 32'h00FFC087);
  endtask

  task automatic t_keep_masks;
    logic [31:0] v;
    wr(10'h182, 32'hFFFF_FFFF); rd(10'h182, v); chk("R6 ier", v, 32'h1F);
    wr(10'h184, 32'hFFFF_FFFF); rd(10'h184, v); chk("R6 txaset", v, 32'hF000_0000);
    wr(10'h185, 32'h5FFF_FFFF); chk("R6 txarst out", tx_act_rst_o, 32'h5000_0000);
    wr(10'h190, 32'hFFFF_FFFF); chk("R6 rxaset out", rx_act_set_o, 32'hC000_0000);
    wr(10'h191, 32'h7FFF_FFFF); rd(10'h191, v); chk("R6 rxarst", v, 32'h4000_0000);
  endtask

  task automatic t_status;
    logic [31:0] v;
    @(negedge clk); tx_eob_set = 32'h0000_000F; err_set = 32'h8000_0001;
    @(negedge clk); tx_eob_set = 0; err_set = 0;
    @(negedge clk); tx_eob_set = 32'h0000_0100;
    @(negedge clk); tx_eob_set = 0;
    rd(10'h186, v); chk("R5 accumulate", v, 32'h0000_010F);
    wr(10'h186, 32'h0000_0105); rd(10'h186, v); chk("R4 w1c tx eob", v, 32'h0000_000A);
    wr(10'h181, 32'h0000_0000); rd(10'h181, v); chk("R4 write zero keeps", v, 32'h8000_0001);
    wr(10'h181, 32'h8000_0000); rd(10'h181, v); chk("R4 w1c err", v, 32'h0000_0001);
    // set and clear on the same bit in the same cycle
    @(negedge clk);
    reg_we = 1; reg_addr = 10'h186; reg_wdata = 32'h0000_000A; tx_eob_set = 32'h0000_0002;
    @(negedge clk);
    reg_we = 0; tx_eob_set = 0;
    rd(10'h186, v); chk("R5 set wins", v, 32'h0000_0002);
    @(negedge clk); rx_derr_set = 32'h0000_0003; rx_eob_set = 32'h0000_0001; tx_derr_set = 32'h4;
    @(negedge clk); rx_derr_set = 0; rx_eob_set = 0; tx_derr_set = 0;
    rd(10'h193, v); chk("R5 rx derr", v, 32'h3);
    rd(10'h192, v); chk("R5 rx eob", v, 32'h1);
    wr(10'h187, 32'hFFFF_FFFF); rd(10'h187, v); chk("R4 w1c tx derr", v, 0);
  endtask

  task automatic t_windows;
    logic [31:0] v;
    wr(10'h1A0, 32'hDEAD_BEEF);
    wr(10'h1A0 + TXN - 1, 32'h1234_5678);
    wr(10'h1A0 + TXN, 32'hAAAA_5555);
    rd(10'h1A0, v); chk("R7 txptr0", v, 32'hDEAD_BEEF);
    rd(10'h1A0 + TXN - 1, v); chk("R7 txptr last", v, 32'h1234_5678);
    rd(10'h1A0 + TXN, v); chk("R8 txptr beyond", v, 0);
    wr(10'h1C0 + RXN - 1, 32'h0BAD_F00D); rd(10'h1C0 + RXN - 1, v); chk("R7 rxptr", v, 32'h0BAD_F00D);
    wr(10'h1C0 + RXN, 32'h1111_1111); rd(10'h1C0 + RXN, v); chk("R8 rxptr beyond", v, 0);
    wr(10'h1E0, 32'hFFFF_FF3C); rd(10'h1E0, v); chk("R7 rxbsz", v, 32'h3C);
    wr(10'h1E0 + RXN, 32'h77); rd(10'h1E0 + RXN, v); chk("R8 rxbsz beyond", v, 0);
    rd(10'h1E0 + RXN - 1 - 1, v); chk("R8 rxbsz0 intact", v, 32'h3C);
    wr(10'h183, 32'hFFFF_FFFF); rd(10'h183, v); chk("R8 unmapped", v, 0);
  endtask

  task automatic t_irq;
    // current: err=1, txeob=2, txderr=0, rxeob=1, rxderr=3
    wr(10'h182, 32'h1F);
    #1; chk("R9 all enabled", {27'd0, irq_o}, 32'b11011);
    wr(10'h182, 32'h1D);
    #1; chk("R9 txeob masked", {27'd0, irq_o}, 32'b11001);
    wr(10'h181, 32'h1);
    #1; chk("R9 err cleared", {27'd0, irq_o}, 32'b11000);
  endtask

  task automatic t_soft;
    logic [31:0] v;
    @(negedge clk); tx_eob_set = 32'h10;
    @(negedge clk); tx_eob_set = 0;
    wr(10'h180, 32'h8123_4567);
    rd(10'h180, v); chk("R3 cfg stored", v, 32'h8123_4567 & 32'h00FFC087);
    rd(10'h182, v); chk("R3 ier cleared", v, 0);
    rd(10'h186, v); chk("R3 txeob cleared", v, 0);
    rd(10'h193, v); chk("R3 rxderr cleared", v, 0);
    chk("R3 txaset cleared", tx_act_set_o, 0);
    chk("R3 rxaset cleared", rx_act_set_o, 0);
    chk("R3 irq low", {27'd0, irq_o}, 0);
    rd(10'h1A0, v); chk("R3 txptr kept", v, 32'hDEAD_BEEF);
    rd(10'h1E0, v); chk("R3 rxbsz kept", v, 32'h3C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cfg_mask();
    t_keep_masks();
    t_status();
    t_windows();
    t_irq();
    t_soft();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog got=%08h exp=%08h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule